// File: doc/BRIEF.md
# Data Pointer Addressing Unit

This unit sits beside the load/store path of a small Harvard-style controller and turns pointer registers into memory addresses. It holds six registers: two linear 16-bit data pointers, a 16-bit frame base, an 8-bit frame offset, a stack pointer and a code pointer. Each access cycle names one pointer, says whether the access reads or writes, and asks for an increment, a decrement or no step. The unit shows the address for that access on a combinational output. The selected pointer is updated at the next clock edge.

The step rule depends on the direction of the access. A read uses the present pointer value and moves the pointer afterwards. A write moves the pointer first and then uses the moved value. The frame pointer is the base plus the offset, and stepping it changes only the offset. The code pointer serves program-memory reads only.

The core loads any register directly through a separate write port. A load to a register takes priority over a step aimed at that same register in the same cycle. All six registers are visible on output ports.

Top module: `ptr_addr_unit`

## Requirements
- R1: After an active-low reset every pointer register reads zero. With no access running, the address output is zero.
- R2: When `wr_en` is high, `wr_sel` picks the register loaded from `wr_data` at the clock edge. The codes are 0 data pointer 0, 1 data pointer 1, 2 frame base, 3 frame offset (takes the low 8 bits only), 4 stack pointer, 5 code pointer. Codes 6 and 7 change nothing.
- R3: `acc_step` uses the codes 0 none, 1 increment, 2 decrement, 3 none. For a read access (`acc_write`=0) that steps, the address is the pointer value before the step, and the pointer holds the stepped value after the edge.
- R4: For a write access that steps, the address is the stepped value, and that same value is stored in the pointer at the edge.
- R5: When `acc_sel`=2 the address is frame base plus zero-extended offset, modulo 2^16. A frame step changes only the offset, which wraps modulo 256. The base keeps its value.
- R6: Data pointers, stack pointer and code pointer wrap modulo 2^16 when stepped, so 0xFFFF+1 gives 0x0000 and 0x0000-1 gives 0xFFFF.
- R7: `acc_sel` codes are 0 data pointer 0, 1 data pointer 1, 2 frame, 3 stack pointer, 4 code pointer. Codes 5 to 7 give address zero and step no register.
- R8: Code-pointer reads step after the access. A write access with `acc_sel`=4 uses the code pointer as the address and does not step it.
- R9: A register load has priority over a step on the same register in the same cycle. A load to the frame base during a frame step takes effect, and the offset step also takes effect.
- R10: When `acc_valid` is low no register steps. The address output still shows the selected pointer's current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is running this cycle |
| acc_sel | input | 3 | Pointer used by the access |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| acc_step | input | 2 | Step mode: none, increment or decrement |
| wr_en | input | 1 | Direct register load enable |
| wr_sel | input | 3 | Register to load |
| wr_data | input | 16 | Load value |
| eff_addr | output | 16 | Address of the current access |
| ptr_dp0 | output | 16 | Data pointer 0 |
| ptr_dp1 | output | 16 | Data pointer 1 |
| ptr_bp | output | 16 | Frame base |
| ptr_offs | output | 8 | Frame offset |
| ptr_sp | output | 16 | Stack pointer |
| ptr_cp | output | 16 | Code pointer |

## Verification
A wrong step direction or wrong step timing shows up on the address output. For a write access it is visible in the same cycle, because the address already carries the stepped value. For a read access it is visible on the pointer port one edge later. A frame step that disturbs the base shows on the base port right after the edge, and it also skews every later frame address. A lost load priority leaves the pointer off by one from the loaded value on the next cycle. A reference model runs one cycle at a time and compares the address in every cycle and all six registers after every edge, so each of these faults is caught within one cycle.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;

  typedef enum logic [2:0] {
    ASEL_DP0 = 3'd0,
    ASEL_DP1 = 3'd1,
    ASEL_FP  = 3'd2,
    ASEL_SP  = 3'd3,
    ASEL_CP  = 3'd4
  } acc_sel_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_RSVD = 2'd3
  } step_mode_e;

  typedef enum logic [2:0] {
    RSEL_DP0  = 3'd0,
    RSEL_DP1  = 3'd1,
    RSEL_BP   = 3'd2,
    RSEL_OFFS = 3'd3,
    RSEL_SP   = 3'd4,
    RSEL_CP   = 3'd5
  } reg_sel_e;

  // linear (non-frame) pointers held in a generated bank
  localparam int NLIN = 4;

endpackage

// File: rtl/ptr_step_unit.sv
module ptr_step_unit
  import ptr_addr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [1:0]   mode,
  output logic [W-1:0] nxt
);

  function automatic logic [W-1:0] step_fn(logic [W-1:0] v, logic [1:0] m);
    case (m)
      STEP_UP:   return v + W'(1);
      STEP_DOWN: return v - W'(1);
      default:   return v;
    endcase
  endfunction

  assign nxt = step_fn(cur, mode);

endmodule

// File: rtl/ptr_cell.sv
module ptr_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         step_en,
  input  logic [W-1:0] step_val,
  output logic [W-1:0] q
);

  // a direct load outranks a step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (ld_en)   q <= ld_val;
    else if (step_en) q <= step_val;
  end

endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
  import ptr_addr_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [2:0]    acc_sel,
  input  logic          acc_write,
  input  logic [1:0]    acc_step,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] ptr_dp0,
  output logic [AW-1:0] ptr_dp1,
  output logic [AW-1:0] ptr_bp,
  output logic [OW-1:0] ptr_offs,
  output logic [AW-1:0] ptr_sp,
  output logic [AW-1:0] ptr_cp
);

  localparam int LW = $clog2(NLIN);

  function automatic logic [LW-1:0] lin_index(logic [2:0] s);
    case (s)
      ASEL_DP1: return LW'(1);
      ASEL_SP:  return LW'(2);
      ASEL_CP:  return LW'(3);
      default:  return LW'(0);
    endcase
  endfunction

  function automatic logic [2:0] lin_load_code(int i);
    case (i)
      1:       return RSEL_DP1;
      2:       return RSEL_SP;
      3:       return RSEL_CP;
      default: return RSEL_DP0;
    endcase
  endfunction

  function automatic logic [AW-1:0] frame_sum(logic [AW-1:0] base, logic [OW-1:0] off);
    return base + {{(AW-OW){1'b0}}, off};
  endfunction

  // access decode, named for the checker
  logic          sel_lin, sel_fp, cp_wr_block, step_mode_ok, step_fire, pre_use;
  logic [LW-1:0] lin_idx;

  assign sel_lin      = (acc_sel == ASEL_DP0) || (acc_sel == ASEL_DP1) ||
                        (acc_sel == ASEL_SP)  || (acc_sel == ASEL_CP);
  assign sel_fp       = (acc_sel == ASEL_FP);
  assign cp_wr_block  = (acc_sel == ASEL_CP) && acc_write;
  assign step_mode_ok = (acc_step == STEP_UP) || (acc_step == STEP_DOWN);
  assign step_fire    = acc_valid && step_mode_ok && !cp_wr_block && (sel_lin || sel_fp);
  assign pre_use      = step_fire && acc_write;
  assign lin_idx      = lin_index(acc_sel);

  // linear pointer bank
  logic [AW-1:0]   lin_q  [NLIN];
  logic [AW-1:0]   lin_nx [NLIN];
  logic [NLIN-1:0] lin_step_en, lin_ld_en;

  for (genvar i = 0; i < NLIN; i++) begin : g_lin
    localparam logic [LW-1:0] LIN_ID  = LW'(i);
    localparam logic [2:0]    LD_CODE = lin_load_code(i);

    assign lin_step_en[i] = step_fire && sel_lin && (lin_idx == LIN_ID);
    assign lin_ld_en[i]   = wr_en && (wr_sel == LD_CODE);

    ptr_step_unit #(.W(AW)) u_step (
      .cur (lin_q[i]),
      .mode(acc_step),
      .nxt (lin_nx[i])
    );

    ptr_cell #(.W(AW)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (lin_ld_en[i]),
      .ld_val  (wr_data),
      .step_en (lin_step_en[i]),
      .step_val(lin_nx[i]),
      .q       (lin_q[i])
    );
  end

  // frame pointer: base never steps, offset does
  logic [OW-1:0] offs_q, offs_nx;
  logic [AW-1:0] bp_q;
  logic          offs_step_en, offs_ld_en, bp_ld_en;

  assign offs_step_en = step_fire && sel_fp;
  assign offs_ld_en   = wr_en && (wr_sel == RSEL_OFFS);
  assign bp_ld_en     = wr_en && (wr_sel == RSEL_BP);

  ptr_step_unit #(.W(OW)) u_offs_step (
    .cur (offs_q),
    .mode(acc_step),
    .nxt (offs_nx)
  );

  ptr_cell #(.W(OW)) u_offs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (offs_ld_en),
    .ld_val  (wr_data[OW-1:0]),
    .step_en (offs_step_en),
    .step_val(offs_nx),
    .q       (offs_q)
  );

  ptr_cell #(.W(AW)) u_bp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (bp_ld_en),
    .ld_val  (wr_data),
    .step_en (1'b0),
    .step_val('0),
    .q       (bp_q)
  );

  // effective address: writes see the stepped value, reads the held one
  logic [AW-1:0] lin_addr, fp_addr;
  assign lin_addr = pre_use ? lin_nx[lin_idx] : lin_q[lin_idx];
  assign fp_addr  = frame_sum(bp_q, pre_use ? offs_nx : offs_q);

  always_comb begin
    if (sel_lin)     eff_addr = lin_addr;
    else if (sel_fp) eff_addr = fp_addr;
    else             eff_addr = '0;
  end

  assign ptr_dp0  = lin_q[0];
  assign ptr_dp1  = lin_q[1];
  assign ptr_sp   = lin_q[2];
  assign ptr_cp   = lin_q[3];
  assign ptr_bp   = bp_q;
  assign ptr_offs = offs_q;

endmodule

// File: rtl/ptr_addr_chk.sv
module ptr_addr_chk #(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [2:0]    acc_sel,
  input logic          acc_write,
  input logic [1:0]    acc_step,
  input logic          wr_en,
  input logic [2:0]    wr_sel,
  input logic [AW-1:0] wr_data,
  input logic [AW-1:0] eff_addr,
  input logic [AW-1:0] ptr_dp0,
  input logic [AW-1:0] ptr_dp1,
  input logic [AW-1:0] ptr_bp,
  input logic [OW-1:0] ptr_offs,
  input logic [AW-1:0] ptr_sp,
  input logic [AW-1:0] ptr_cp,
  input logic          step_fire
);

  AST_RD_ADDR_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_write && acc_sel == 3'd0) |-> eff_addr == ptr_dp0); // R3

  AST_RD_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_sel == 3'd0 && acc_step == 2'd1 && !(wr_en && wr_sel == 3'd0))
    |=> ptr_dp0 == $past(eff_addr) + AW'(1)); // R3

  AST_WR_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_sel == 3'd1 && (acc_step == 2'd1 || acc_step == 2'd2)
     && !(wr_en && wr_sel == 3'd1))
    |=> ptr_dp1 == $past(eff_addr)); // R4

  AST_FP_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && acc_sel == 3'd2 && !(wr_en && wr_sel == 3'd2)) |=> $stable(ptr_bp)); // R5

  AST_FP_READ_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel == 3'd2 && !acc_write)
    |-> eff_addr == ptr_bp + {{(AW-OW){1'b0}}, ptr_offs}); // R5

  AST_BAD_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel > 3'd4) |-> eff_addr == '0); // R7

  AST_CP_WR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_sel == 3'd4 && !(wr_en && wr_sel == 3'd5))
    |=> $stable(ptr_cp)); // R8

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> ptr_dp0 == $past(wr_data)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !wr_en)
    |=> $stable(ptr_dp0) && $stable(ptr_dp1) && $stable(ptr_offs) && $stable(ptr_sp) && $stable(ptr_cp)); // R10

endmodule

bind ptr_addr_unit ptr_addr_chk #(.AW(AW), .OW(OW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_valid(acc_valid),
  .acc_sel  (acc_sel),
  .acc_write(acc_write),
  .acc_step (acc_step),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .eff_addr (eff_addr),
  .ptr_dp0  (ptr_dp0),
  .ptr_dp1  (ptr_dp1),
  .ptr_bp   (ptr_bp),
  .ptr_offs (ptr_offs),
  .ptr_sp   (ptr_sp),
  .ptr_cp   (ptr_cp),
  .step_fire(step_fire)
);

// File: tb/sim_ptr_addr_unit.sv
module sim_ptr_addr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_sel = '0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_step = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] eff_addr, ptr_dp0, ptr_dp1, ptr_bp, ptr_sp, ptr_cp;
  logic [7:0]  ptr_offs;

  always #5 clk = ~clk;

  ptr_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sel(acc_sel),
    .acc_write(acc_write), .acc_step(acc_step), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .eff_addr(eff_addr), .ptr_dp0(ptr_dp0), .ptr_dp1(ptr_dp1),
    .ptr_bp(ptr_bp), .ptr_offs(ptr_offs), .ptr_sp(ptr_sp), .ptr_cp(ptr_cp)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model registers indexed by load code: dp0 dp1 base offs sp cp
  int m[6];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    chk(tag, "dp0",  int'(ptr_dp0),  m[0]);
    chk(tag, "dp1",  int'(ptr_dp1),  m[1]);
    chk(tag, "base", int'(ptr_bp),   m[2]);
    chk(tag, "offs", int'(ptr_offs), m[3]);
    chk(tag, "sp",   int'(ptr_sp),   m[4]);
    chk(tag, "cp",   int'(ptr_cp),   m[5]);
  endtask

  // one access cycle; called at a falling edge
  task automatic cyc(bit v, int sel, bit wr, int st, bit we, int ws, int wd, string tag);
    int r, delta, modv, nv, shown, exp_addr;
    bit stepping;
    acc_valid = v; acc_sel = 3'(sel); acc_write = wr; acc_step = 2'(st);
    wr_en = we; wr_sel = 3'(ws); wr_data = 16'(wd);
    r = (sel == 0) ? 0 : (sel == 1) ? 1 : (sel == 2) ? 3 : (sel == 3) ? 4 : 5;
    delta = (st == 1) ? 1 : (st == 2) ? -1 : 0;
    stepping = v && (delta != 0) && (sel <= 4) && !(sel == 4 && wr);
    modv = (sel == 2) ? 256 : 65536;
    nv = (m[r] + delta + modv) % modv;
    shown = (wr && stepping) ? nv : m[r];
    if (sel > 4)       exp_addr = 0;
    else if (sel == 2) exp_addr = (m[2] + shown) % 65536;
    else               exp_addr = shown;
    #1;
    chk(tag, "addr", int'(eff_addr), exp_addr);
    if (stepping) m[r] = nv;
    if (we && ws <= 5) m[ws] = (ws == 3) ? (wd % 256) : (wd % 65536);
    @(negedge clk);
    chk_regs(tag);
  endtask

  task automatic load(int ws, int wd, string tag);
    cyc(1'b0, 0, 1'b0, 0, 1'b1, ws, wd, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    bit [31:0] lf;
    foreach (m[i]) m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "addr", int'(eff_addr), 0);
    chk_regs("R1");
    rst_n = 1'b1;
    @(negedge clk);

    // linear wrap on read post-increment
    load(0, 16'hFFFF, "R2");
    cyc(1, 0, 0, 1, 0, 0, 0, "R3 R6");
    cyc(1, 0, 0, 0, 0, 0, 0, "R3");
    cyc(1, 0, 0, 3, 0, 0, 0, "R3");
    // write pre-decrement wraps below zero
    load(1, 0, "R2");
    cyc(1, 1, 1, 2, 0, 0, 0, "R4 R6");
    cyc(1, 1, 1, 1, 0, 0, 0, "R4");
    // frame pointer
    load(2, 16'hFFF0, "R2");
    load(3, 16'h12FF, "R2");
    cyc(1, 2, 1, 1, 0, 0, 0, "R5");
    cyc(1, 2, 0, 2, 0, 0, 0, "R5");
    cyc(1, 2, 0, 0, 0, 0, 0, "R5");
    // stack pointer
    cyc(1, 3, 1, 1, 0, 0, 0, "R4");
    cyc(1, 3, 0, 2, 0, 0, 0, "R3");
    // code pointer
    load(5, 16'h1234, "R2");
    cyc(1, 4, 0, 1, 0, 0, 0, "R8");
    cyc(1, 4, 1, 1, 0, 0, 0, "R8");
    cyc(1, 4, 0, 2, 0, 0, 0, "R8");
    // load priority over step
    cyc(1, 0, 0, 1, 1, 0, 16'hAAAA, "R9");
    cyc(1, 2, 1, 1, 1, 2, 16'h0100, "R9");
    cyc(1, 2, 1, 2, 1, 3, 16'h0077, "R9");
    // unused selects and load codes
    cyc(1, 5, 0, 1, 0, 0, 0, "R7");
    cyc(1, 6, 1, 2, 0, 0, 0, "R7");
    cyc(1, 7, 0, 1, 1, 6, 16'h5555, "R7 R2");
    load(7, 16'h3333, "R2");
    // idle cycles
    cyc(0, 0, 0, 1, 0, 0, 0, "R10");
    cyc(0, 2, 1, 2, 0, 0, 0, "R10");
    cyc(0, 3, 1, 1, 0, 0, 0, "R10");

    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cyc(lf[0] | lf[9], int'(lf[4:2]) % 6, lf[5], int'(lf[7:6]),
          lf[8] & lf[12] & lf[13], int'(lf[16:14]) % 7, int'(lf[31:16]), "R3 R4 R5 R9");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule